// File: doc/BRIEF.md
# Signed Power Gain and Offset Calibrator

This block trims a stream of signed reactive power samples before they are used downstream. Samples belong to one of three phases and to one of two power kinds (total or fundamental). Each of the six phase/kind slots has its own 24-bit signed offset trim and its own 24-bit signed gain trim. The trims are held in twelve registers that are written and read over a small synchronous register bus.

Each accepted sample is 28 bits signed. The block first adds the slot's offset, sign-extended to 28 bits, with saturation. It then multiplies the sum by one plus the gain fraction, where the gain carries 23 fraction bits. The product is truncated toward negative infinity and clamped to the 28-bit signed range. The result leaves two cycles later with a valid strobe and the slot's phase and kind tags. Readback presents each 24-bit register as a 32-bit word. The value is sign-extended through bit 27, and the top nibble is zero.

Top module: `pwr_trim_cal`

## Requirements
- R1: After synchronous reset, out_valid and out_sample are 0 and every register reads back 0.
- R2: Register address layout: bits [1:0] select the phase (0..2), bit 2 selects the kind (0 total, 1 fundamental), and bit 3 selects gain (0) or offset (1). A write with reg_wr high stores reg_wdata[23:0], and the new value is visible on reg_rdata from the next cycle.
- R3: reg_rdata is combinational from reg_addr. Bits [23:0] hold the register value, bits [27:24] repeat bit 23, and bits [31:28] are zero.
- R4: An address whose phase field is 3 reads as 0, and a write to it changes no register.
- R5: A sample taken with in_valid high and in_phase 0..2 produces out_valid high exactly two cycles later, with out_phase and out_kind equal to the sample's phase and kind.
- R6: A sample with in_phase equal to 3 is ignored and produces no out_valid pulse.
- R7: The result equals floor(S × (2^23 + G) / 2^23). S is the 28-bit saturated sum of the input and the slot's sign-extended offset, and G is the slot's signed gain.
- R8: A gain of 0xC00000 halves the value, and a gain of 0x400000 scales it by 1.5, both rounded toward negative infinity (for example, −1001 at half gives −501).
- R9: The offset sum and the final result each clamp to the range +134217727 to −134217728 instead of wrapping.
- R10: While out_valid is low, out_sample holds the last emitted result.
- R11: Each sample uses only the gain and offset of its own phase and kind.
- R12: A register write in the same cycle as a sample affects only later samples. The coincident sample uses the old trims.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (type, kind, phase) |
| reg_wdata | input | 32 | Write data; bits [23:0] are used |
| reg_rdata | output | 32 | Readback word for reg_addr |
| in_valid | input | 1 | Input sample strobe |
| in_phase | input | 2 | Phase of the input sample (0..2) |
| in_kind | input | 1 | 0 total, 1 fundamental |
| in_sample | input | 28 | Signed input power sample |
| out_valid | output | 1 | Result strobe |
| out_phase | output | 2 | Phase of the result |
| out_kind | output | 1 | Kind of the result |
| out_sample | output | 28 | Signed trimmed result |

## Verification
The assertions check the cycle-level properties on every cycle:
- the two-cycle strobe latency and the dropping of phase-3 samples;
- the readback word format and the zero readback of phase-3 addresses;
- the visibility of a write one cycle later;
- the holding of out_sample between strobes.

The arithmetic can only be shown by the bench's scenarios, because it depends on the register contents. These scenarios cover floor rounding at the ±50% gains, clamping of both the offset sum and the product, independence of the six slots, and the ordering of a write against a coincident sample. The bench checks them with a reference model and a scoreboard.

// File: rtl/pwr_trim_pkg.sv
package pwr_trim_pkg;
    // Phase field in the address is two bits wide, so NUM_PH must stay <= 3
    localparam int DATA_W   = 28;
    localparam int REG_W    = 24;
    localparam int FRAC_W   = 23;
    localparam int NUM_PH   = 3;
    localparam int NUM_KIND = 2;
    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 4;
    localparam int NUM_SLOT = NUM_PH * NUM_KIND;
    localparam int SLOT_W   = $clog2(NUM_SLOT);
    localparam int MULT_W   = REG_W + 1;
    localparam int PROD_W   = DATA_W + MULT_W;
    localparam int SHR_W    = PROD_W - FRAC_W;

    typedef enum logic {KIND_TOTAL = 1'b0, KIND_FUND = 1'b1} pwr_kind_e;

    typedef struct packed {
        logic              valid;
        logic [1:0]        phase;
        pwr_kind_e         kind;
        logic [DATA_W-1:0] value;
    } pwr_beat_t;

    typedef struct packed {
        logic              valid;
        logic [1:0]        phase;
        pwr_kind_e         kind;
        logic [DATA_W-1:0] sum;
        logic [REG_W-1:0]  gain;
    } trim_mid_t;

    function automatic logic [SLOT_W-1:0] slot_of(input logic kind, input logic [1:0] phase);
        return SLOT_W'(int'(kind) * NUM_PH + int'(phase));
    endfunction

    function automatic logic [DATA_W-1:0] clamp_sum(input logic [DATA_W:0] x);
        if (x[DATA_W] != x[DATA_W-1])
            return x[DATA_W] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
        return x[DATA_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] clamp_prod(input logic [SHR_W-1:0] x);
        logic [SHR_W-DATA_W:0] top;
        top = x[SHR_W-1:DATA_W-1];
        if (!(&top) && (|top))
            return x[SHR_W-1] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
        return x[DATA_W-1:0];
    endfunction

    function automatic logic [BUS_W-1:0] to_word(input logic [REG_W-1:0] v);
        return {{(BUS_W-DATA_W){1'b0}}, {(DATA_W-REG_W){v[REG_W-1]}}, v};
    endfunction
endpackage

// File: rtl/pwr_trim_regfile.sv
module pwr_trim_regfile
    import pwr_trim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    input  logic [1:0]        lk_phase,
    input  logic              lk_kind,
    output logic [REG_W-1:0]  lk_gain,
    output logic [REG_W-1:0]  lk_ofs
);
    logic [REG_W-1:0] gain_q [NUM_SLOT];
    logic [REG_W-1:0] ofs_q  [NUM_SLOT];
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[BUS_W-1:REG_W];

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        localparam logic [1:0] PH = 2'(s % NUM_PH);
        localparam logic       KD = 1'(s / NUM_PH);
        logic [REG_W-1:0] gain_r, ofs_r;
        logic             hit;
        assign hit = reg_wr && (reg_addr[1:0] == PH) && (reg_addr[2] == KD);
        always_ff @(posedge clk) begin
            if (rst) begin
                gain_r <= '0;
                ofs_r  <= '0;
            end else if (hit) begin
                if (reg_addr[3]) ofs_r  <= reg_wdata[REG_W-1:0];
                else             gain_r <= reg_wdata[REG_W-1:0];
            end
        end
        assign gain_q[s] = gain_r;
        assign ofs_q[s]  = ofs_r;
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr[1:0]) < NUM_PH)
            reg_rdata = to_word(reg_addr[3] ? ofs_q[slot_of(reg_addr[2], reg_addr[1:0])]
                                            : gain_q[slot_of(reg_addr[2], reg_addr[1:0])]);
    end

    always_comb begin
        lk_gain = '0;
        lk_ofs  = '0;
        if (int'(lk_phase) < NUM_PH) begin
            lk_gain = gain_q[slot_of(lk_kind, lk_phase)];
            lk_ofs  = ofs_q[slot_of(lk_kind, lk_phase)];
        end
    end
endmodule

// File: rtl/pwr_trim_offset_stage.sv
module pwr_trim_offset_stage
    import pwr_trim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pwr_beat_t        beat_i,
    input  logic [REG_W-1:0] ofs_i,
    input  logic [REG_W-1:0] gain_i,
    output trim_mid_t        mid_o
);
    logic [DATA_W:0] wide_sum;

    assign wide_sum = {beat_i.value[DATA_W-1], beat_i.value}
                    + {{(DATA_W+1-REG_W){ofs_i[REG_W-1]}}, ofs_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_o <= '0;
        end else begin
            mid_o.valid <= beat_i.valid && (int'(beat_i.phase) < NUM_PH);
            mid_o.phase <= beat_i.phase;
            mid_o.kind  <= beat_i.kind;
            mid_o.sum   <= clamp_sum(wide_sum);
            mid_o.gain  <= gain_i;
        end
    end
endmodule

// File: rtl/pwr_trim_gain_stage.sv
module pwr_trim_gain_stage
    import pwr_trim_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  trim_mid_t mid_i,
    output pwr_beat_t beat_o
);
    logic signed [PROD_W-1:0] sum_x, mult_x, prod;
    logic                     unused_frac;

    always_comb begin
        sum_x  = PROD_W'($signed(mid_i.sum));
        mult_x = PROD_W'($signed({mid_i.gain[REG_W-1], mid_i.gain}))
               + (PROD_W'(1) <<< FRAC_W);
        prod   = sum_x * mult_x;
    end

    assign unused_frac = ^prod[FRAC_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_o <= '0;
        end else begin
            beat_o.valid <= mid_i.valid;
            if (mid_i.valid) begin
                beat_o.phase <= mid_i.phase;
                beat_o.kind  <= mid_i.kind;
                beat_o.value <= clamp_prod(prod[PROD_W-1:FRAC_W]);
            end
        end
    end
endmodule

// File: rtl/pwr_trim_cal.sv
module pwr_trim_cal
    import pwr_trim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    input  logic              in_valid,
    input  logic [1:0]        in_phase,
    input  logic              in_kind,
    input  logic [DATA_W-1:0] in_sample,
    output logic              out_valid,
    output logic [1:0]        out_phase,
    output logic              out_kind,
    output logic [DATA_W-1:0] out_sample
);
    pwr_beat_t        beat_in, beat_out;
    trim_mid_t        mid;
    logic [REG_W-1:0] sel_gain, sel_ofs;

    assign beat_in = '{valid: in_valid, phase: in_phase,
                       kind: pwr_kind_e'(in_kind), value: in_sample};

    pwr_trim_regfile u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_phase(in_phase), .lk_kind(in_kind), .lk_gain(sel_gain), .lk_ofs(sel_ofs)
    );

    pwr_trim_offset_stage u_ofs (
        .clk(clk), .rst(rst), .beat_i(beat_in), .ofs_i(sel_ofs), .gain_i(sel_gain), .mid_o(mid)
    );

    pwr_trim_gain_stage u_gain (
        .clk(clk), .rst(rst), .mid_i(mid), .beat_o(beat_out)
    );

    assign out_valid  = beat_out.valid;
    assign out_phase  = beat_out.phase;
    assign out_kind   = beat_out.kind;
    assign out_sample = beat_out.value;
endmodule

// File: rtl/pwr_trim_cal_chk.sv
module pwr_trim_cal_chk
    import pwr_trim_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [BUS_W-1:0]  reg_wdata,
    input logic [BUS_W-1:0]  reg_rdata,
    input logic              in_valid,
    input logic [1:0]        in_phase,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_sample
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2) |-> (out_valid == $past(in_valid && (int'(in_phase) < NUM_PH), 2))); // R5 R6

    AST_WORD_FORMAT: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[BUS_W-1:DATA_W] == '0) &&
        (reg_rdata[DATA_W-1:REG_W] == {(DATA_W-REG_W){reg_rdata[REG_W-1]}})); // R3

    AST_BAD_PHASE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (int'(reg_addr[1:0]) >= NUM_PH) |-> (reg_rdata == '0)); // R4

    AST_WRITE_SEEN: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (int'(reg_addr[1:0]) < NUM_PH)) |=>
        ($stable(reg_addr) -> (reg_rdata[REG_W-1:0] == $past(reg_wdata[REG_W-1:0])))); // R2

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 1 && !out_valid) |-> $stable(out_sample)); // R10
endmodule

bind pwr_trim_cal pwr_trim_cal_chk u_chk (.*);

// File: tb/pwr_trim_cal_tb_top.sv
module pwr_trim_cal_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [1:0]  in_phase = '0;
    logic        in_kind = 1'b0;
    logic [27:0] in_sample = '0;
    logic        out_valid;
    logic [1:0]  out_phase;
    logic        out_kind;
    logic [27:0] out_sample;

    typedef struct {int ph; int kd; logic [27:0] val;} exp_t;
    exp_t        sb_q[$];
    logic [23:0] gain_m [2][3];
    logic [23:0] ofs_m  [2][3];
    int          errors = 0, checks = 0;
    logic [27:0] last_out = '0;
    bit          done = 0;

    always #2 clk = ~clk;

    pwr_trim_cal dut_i (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    function automatic longint clampl(input longint v);
        if (v > 134217727)  return 134217727;
        if (v < -134217728) return -134217728;
        return v;
    endfunction

    function automatic logic [27:0] ref_cal(input int ph, input int kd, input logic [27:0] x);
        longint s, m, p;
        s = clampl(longint'($signed(x)) + longint'($signed(ofs_m[kd][ph])));
        m = (longint'(1) <<< 23) + longint'($signed(gain_m[kd][ph]));
        p = (s * m) >>> 23;
        return 28'(clampl(p));
    endfunction

    // Scoreboard monitor: compares results, and checks hold when idle (R10)
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    chk("R6", "unexpected result", {4'h0, out_sample}, 32'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk("R7", "result value", {4'h0, out_sample}, {4'h0, e.val});
                    chk("R5", "result tags", {29'h0, out_kind, out_phase}, {29'h0, 1'(e.kd), 2'(e.ph)});
                end
                last_out = out_sample;
            end else begin
                chk("R10", "idle hold", {4'h0, out_sample}, {4'h0, last_out});
            end
        end
    end

    // All tasks start and end just after a falling edge
    task automatic wr_reg(input logic [3:0] a, input logic [23:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = {8'hA5, v};
        @(negedge clk);
        reg_wr = 1'b0;
        if (a[1:0] != 2'd3) begin
            if (a[3]) ofs_m[a[2]][a[1:0]] = v;
            else      gain_m[a[2]][a[1:0]] = v;
        end
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, "readback", reg_rdata, exp);
        @(negedge clk);
    endtask

    task automatic send(input int ph, input int kd, input logic [27:0] x);
        in_valid = 1'b1; in_phase = 2'(ph); in_kind = 1'(kd); in_sample = x;
        if (ph < 3) sb_q.push_back('{ph, kd, ref_cal(ph, kd, x)});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 2; k++)
            for (int p = 0; p < 3; p++) begin gain_m[k][p] = '0; ofs_m[k][p] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "out_valid after reset", {31'h0, out_valid}, 32'h0);
        chk("R1", "out_sample after reset", {4'h0, out_sample}, 32'h0);
        for (int a = 0; a < 16; a++) rd_chk("R1", 4'(a), 32'h0);

        // R7: zero trims pass through
        send(0, 0, 28'd1000);
        send(0, 0, -28'sd1000);
        drain();

        // R2 R3: writes and readback word format
        wr_reg(4'b0000, 24'hC00000);
        rd_chk("R3", 4'b0000, 32'h0FC00000);
        wr_reg(4'b0001, 24'h400000);
        rd_chk("R2", 4'b0001, 32'h00400000);
        wr_reg(4'b1110, 24'hFFFFF0);
        rd_chk("R3", 4'b1110, 32'h0FFFFFF0);

        // R8: half and one-and-a-half gains with floor rounding
        send(0, 0, 28'd1001);
        send(0, 0, -28'sd1001);
        send(1, 0, 28'd1000);
        send(2, 1, 28'd100);
        drain();
        chk("R8", "half of -1001 model", {4'h0, ref_cal(0, 0, -28'sd1001)}, {4'h0, -28'sd501});

        // R11: same phase, other kind untouched
        send(0, 1, 28'd1000);
        send(1, 1, 28'd1000);
        drain();

        // R9: saturation of product and of offset sum
        wr_reg(4'b0010, 24'h7FFFFF);
        send(2, 0, 28'h7FFFFFF);
        send(2, 0, 28'h8000000);
        wr_reg(4'b1101, 24'h7FFFFF);
        send(1, 1, 28'h7FFFF9C);
        drain();

        // R4: phase field 3 in address
        wr_reg(4'b0011, 24'h123456);
        rd_chk("R4", 4'b0011, 32'h0);
        rd_chk("R4", 4'b1111, 32'h0);
        rd_chk("R4", 4'b0010, 32'h007FFFFF);

        // R6: phase 3 sample ignored
        begin
            int seen;
            seen = 0;
            send(3, 0, 28'd77);
            repeat (4) begin
                if (out_valid) seen++;
                @(negedge clk);
            end
            chk("R6", "pulses for phase 3", 32'(seen), 32'h0);
        end

        // R5: latency exactly two cycles
        in_valid = 1'b1; in_phase = 2'd1; in_kind = 1'b0; in_sample = 28'd8;
        sb_q.push_back('{1, 0, ref_cal(1, 0, 28'd8)});
        @(negedge clk);
        in_valid = 1'b0;
        chk("R5", "out_valid after one cycle", {31'h0, out_valid}, 32'h0);
        @(negedge clk);
        chk("R5", "out_valid after two cycles", {31'h0, out_valid}, 32'h1);
        drain();

        // R12: write coincident with a sample
        reg_wr = 1'b1; reg_addr = 4'b1000; reg_wdata = 32'h00000100;
        in_valid = 1'b1; in_phase = 2'd0; in_kind = 1'b0; in_sample = 28'd400;
        sb_q.push_back('{0, 0, ref_cal(0, 0, 28'd400)});
        @(negedge clk);
        reg_wr = 1'b0; in_valid = 1'b0;
        ofs_m[0][0] = 24'h000100;
        send(0, 0, 28'd400);
        drain();
        chk("R12", "model old vs new differ", {4'h0, ref_cal(0, 0, 28'd400)}, {4'h0, 28'd328});

        // R7 R11: back-to-back mixed traffic with interleaved trims
        for (int i = 0; i < 60; i++) begin
            if (i % 7 == 3) wr_reg({1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                                     2'($urandom_range(2, 0))}, 24'($urandom));
            send($urandom_range(2, 0), $urandom_range(1, 0), 28'($urandom));
        end
        drain();
        chk("R7", "scoreboard empty", 32'(sb_q.size()), 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule